// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block sits between a synchronous host and an asynchronous 4-bit-wide dynamic RAM with a multiplexed address bus. The host posts single-word reads and writes over a valid/ready handshake with a 22-bit word address. The controller turns each request into strobe sequences on the row strobe, the column strobe, the write-enable and the output-enable pins. It drives the row half of the address first and the column half afterwards on the same pins. Read data comes back on a one-cycle valid pulse.

A row stays open after an access. Later requests that hit the same row are served with column strobes only, so no new row activation is needed. The page closes when a request targets another row, when a refresh is due, or when another column access would push the row-strobe low time past its limit. Refresh uses the CAS-before-RAS form from a free-running interval counter and takes priority over host traffic. After reset the controller holds off the host through a long power-up pause and a run of refresh cycles. Every timing value is a nanosecond parameter that is converted to clock cycles by rounding up.

Top module: `dramc_ctrl`

## Requirements
- R1: The row part of the address, `req_addr[21:10]`, is on `dram_addr` when `dram_ras_n` falls for an access. The column part, `req_addr[9:0]`, is on `dram_addr[9:0]` with `dram_addr[11:10]` at zero when `dram_cas_n` falls.
- R2: A read holds `dram_we_n` high and `dram_oe_n` low while the column strobe is low. It returns the addressed word on `rd_data` with `rd_valid` high for exactly one cycle, in request order.
- R3: A write is an early write. `dram_we_n` is already low in the cycle before `dram_cas_n` falls. When the column strobe falls, `dram_dq_oe` is high, `dram_dq_out` holds the write data and `dram_oe_n` is high.
- R4: A request to the row that is already open is served without raising `dram_ras_n`. Back-to-back same-row requests cause a single row activation.
- R5: Before every fall of `dram_ras_n`, the strobe has been high for at least the precharge time in cycles (2 with the default parameters).
- R6: `dram_ras_n` is never low for more than `T_RASMAX_NS / T_CLK_NS` consecutive cycles. A long same-row burst is split into more than one activation.
- R7: Refresh is CAS-before-RAS. `dram_cas_n` is low in the cycle before `dram_ras_n` falls, `dram_we_n` is high at that fall, and the address pins are not used. With no host traffic, successive refreshes start exactly one refresh interval apart.
- R8: A due refresh is served ahead of pending host requests and closes an open page. Under continuous host traffic, the spacing of refreshes exceeds the interval by no more than the length of one bounded access.
- R9: After reset, `req_ready` stays low for the power-up pause and until eight refresh cycles have completed.
- R10: During reset, all strobes (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_oe_n`) are high, `dram_dq_oe` is low, and `req_ready` and `rd_valid` are low.
- R11: Each timing is the ceiling of its nanosecond value divided by `T_CLK_NS`. For example, a refresh interval of 15610 ns at a 20 ns clock gives 781 cycles, and a 200000 ns pause gives 10000 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken on this edge when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in the upper 12 bits |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle pulse marking returned read data |
| rd_data | output | 4 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 12 | Multiplexed address pins |
| dram_dq_out | output | 4 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Enables the data pin drivers |
| dram_dq_in | input | 4 | Data returned by the memory |

## Verification
The bench goes after the places where an open page meets other events:
- A same-row burst right after a refresh. A controller that closes the page every time shows extra activations.
- A burst long enough to cross the row-strobe limit. A controller with no limit leaves the strobe low too long and shows a single activation.
- Refreshes measured while idle and under saturating traffic. A wrong priority or wrong rounding shows up as a drifting or stretched refresh spacing.

Read data is checked end to end against a memory model that latches rows and columns from the pins, so a swapped address field or late capture gives a mismatch. The write-enable timing at each column strobe is also checked, which catches a late write that would let the memory drive the bus.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

    parameter int unsigned ROW_W  = 12;
    parameter int unsigned COL_W  = 10;
    parameter int unsigned DQ_W   = 4;
    parameter int unsigned ADDR_W = ROW_W + COL_W;

    typedef enum logic [3:0] {
        ST_INIT, ST_IDLE, ST_ROW, ST_COL, ST_CAS, ST_CP,
        ST_PRE, ST_RCAS, ST_RRAS, ST_RPRE
    } dstate_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             wr;
        logic [DQ_W-1:0]  wd;
    } acc_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
        logic row_sel;
        logic col_sel;
    } pins_t;

    function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned sub_min1(int unsigned a, int unsigned b);
        return (a > b) ? (a - b) : 1;
    endfunction

    function automatic pins_t pins_of(dstate_e st, logic wr);
        pins_t p;
        p = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
              dq_oe: 1'b0, row_sel: 1'b0, col_sel: 1'b0};
        case (st)
            ST_ROW: begin
                p.ras_n   = 1'b0;
                p.row_sel = 1'b1;
            end
            ST_COL: begin
                p.ras_n   = 1'b0;
                p.col_sel = 1'b1;
                p.we_n    = ~wr;
                p.dq_oe   = wr;
            end
            ST_CAS: begin
                p.ras_n   = 1'b0;
                p.cas_n   = 1'b0;
                p.col_sel = 1'b1;
                p.we_n    = ~wr;
                p.dq_oe   = wr;
                p.oe_n    = wr;
            end
            ST_CP:   p.ras_n = 1'b0;
            ST_RCAS: p.cas_n = 1'b0;
            ST_RRAS: begin
                p.ras_n = 1'b0;
                p.cas_n = 1'b0;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dramc_wait_timer.sv
module dramc_wait_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= load_val;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/dramc_refresh_timer.sv
module dramc_refresh_timer #(
    parameter int unsigned PERIOD = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic pending
);
    localparam int unsigned CW = $clog2(PERIOD + 1);
    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == CW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick)     pending <= 1'b1;
            else if (ack) pending <= 1'b0;
        end
    end
endmodule

// File: rtl/dramc_ras_guard.sv
module dramc_ras_guard #(
    parameter int unsigned MIN_CYC  = 4,
    parameter int unsigned MAX_CYC  = 5000,
    parameter int unsigned SPAN_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ras_low,
    output logic min_met,
    output logic near_limit
);
    localparam int unsigned CW = $clog2(MAX_CYC + 2);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                         cnt <= '0;
        else if (!ras_low)               cnt <= '0;
        else if (cnt != CW'(MAX_CYC + 1)) cnt <= cnt + 1'b1;
    end

    assign min_met    = (32'(cnt) + 32'd1 >= MIN_CYC);
    assign near_limit = (32'(cnt) + 32'd1 + SPAN_CYC >= MAX_CYC);
endmodule

// File: rtl/dramc_ctrl.sv
module dramc_ctrl
    import dramc_pkg::*;
#(
    parameter int unsigned T_CLK_NS    = 20,
    parameter int unsigned T_INIT_NS   = 200000,
    parameter int unsigned T_REFI_NS   = 15600,
    parameter int unsigned T_RASMAX_NS = 100000,
    parameter int unsigned T_RC_NS     = 110,
    parameter int unsigned T_RAS_NS    = 60,
    parameter int unsigned T_RP_NS     = 40,
    parameter int unsigned T_CAS_NS    = 15,
    parameter int unsigned T_CAC_NS    = 15,
    parameter int unsigned T_CP_NS     = 10,
    parameter int unsigned T_PC_NS     = 35,
    parameter int unsigned T_RAH_NS    = 10,
    parameter int unsigned T_CSR_NS    = 5,
    parameter int unsigned T_CHR_NS    = 10,
    parameter int unsigned INIT_REFS   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [ROW_W-1:0]  dram_addr,
    output logic [DQ_W-1:0]   dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DQ_W-1:0]   dram_dq_in
);
    localparam int unsigned INIT_CYC   = umax(1, ns2cyc(T_INIT_NS, T_CLK_NS));
    localparam int unsigned REFI_CYC   = umax(2, ns2cyc(T_REFI_NS, T_CLK_NS));
    localparam int unsigned RP_CYC     = umax(1, ns2cyc(T_RP_NS, T_CLK_NS));
    localparam int unsigned RAS_MIN    = umax(umax(ns2cyc(T_RAS_NS, T_CLK_NS),
                                                   ns2cyc(T_CHR_NS, T_CLK_NS)),
                                              sub_min1(ns2cyc(T_RC_NS, T_CLK_NS), RP_CYC));
    localparam int unsigned RAH_CYC    = umax(1, ns2cyc(T_RAH_NS, T_CLK_NS));
    localparam int unsigned CSR_CYC    = umax(1, ns2cyc(T_CSR_NS, T_CLK_NS));
    localparam int unsigned CASL_CYC   = umax(1, umax(ns2cyc(T_CAS_NS, T_CLK_NS),
                                                      ns2cyc(T_CAC_NS, T_CLK_NS)));
    localparam int unsigned CP_CYC     = umax(umax(1, ns2cyc(T_CP_NS, T_CLK_NS)),
                                              sub_min1(ns2cyc(T_PC_NS, T_CLK_NS), 1 + CASL_CYC));
    localparam int unsigned PAGE_SPAN  = 1 + CASL_CYC + CP_CYC;
    localparam int unsigned RASMAX_CYC = T_RASMAX_NS / T_CLK_NS;
    localparam int unsigned TW         = $clog2(umax(INIT_CYC, RAS_MIN + RP_CYC + CP_CYC
                                                     + CSR_CYC + RAH_CYC + CASL_CYC) + 1);
    localparam int unsigned IW         = $clog2(INIT_REFS + 1);

    dstate_e         state, state_n;
    acc_t            acc_q;
    pins_t           pins;
    logic            wt_done, wt_load;
    logic [TW-1:0]   wt_val;
    logic            ref_pending, ref_ack;
    logic            min_met, near_limit;
    logic [IW-1:0]   init_left;
    logic            accept;
    logic            row_hit;
    int unsigned     dur_n;

    dramc_wait_timer #(.W(TW)) u_wait (
        .clk(clk), .rst(rst), .load(wt_load), .load_val(wt_val), .done(wt_done)
    );

    dramc_refresh_timer #(.PERIOD(REFI_CYC)) u_refi (
        .clk(clk), .rst(rst), .ack(ref_ack), .pending(ref_pending)
    );

    dramc_ras_guard #(.MIN_CYC(RAS_MIN), .MAX_CYC(RASMAX_CYC), .SPAN_CYC(PAGE_SPAN)) u_guard (
        .clk(clk), .rst(rst), .ras_low(!pins.ras_n), .min_met(min_met), .near_limit(near_limit)
    );

    assign row_hit = (req_addr[ADDR_W-1:COL_W] == acc_q.row);

    always_comb begin
        state_n = state;
        accept  = 1'b0;
        case (state)
            ST_INIT: if (wt_done) state_n = ST_RCAS;
            ST_IDLE: begin
                if (ref_pending)    state_n = ST_RCAS;
                else if (req_valid) begin
                    accept  = 1'b1;
                    state_n = ST_ROW;
                end
            end
            ST_ROW:  if (wt_done) state_n = ST_COL;
            ST_COL:  if (wt_done) state_n = ST_CAS;
            ST_CAS:  if (wt_done) state_n = ST_CP;
            ST_CP: begin
                if (wt_done) begin
                    if (ref_pending || near_limit || (req_valid && !row_hit)) begin
                        if (min_met) state_n = ST_PRE;
                    end else if (req_valid) begin
                        accept  = 1'b1;
                        state_n = ST_COL;
                    end
                end
            end
            ST_PRE:  if (wt_done) state_n = ST_IDLE;
            ST_RCAS: if (wt_done) state_n = ST_RRAS;
            ST_RRAS: if (wt_done) state_n = ST_RPRE;
            ST_RPRE: if (wt_done) state_n = (init_left > IW'(1)) ? ST_RCAS : ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        case (state_n)
            ST_INIT:          dur_n = INIT_CYC;
            ST_ROW:           dur_n = RAH_CYC;
            ST_CAS:           dur_n = CASL_CYC;
            ST_CP:            dur_n = CP_CYC;
            ST_PRE, ST_RPRE:  dur_n = RP_CYC;
            ST_RCAS:          dur_n = CSR_CYC;
            ST_RRAS:          dur_n = RAS_MIN;
            default:          dur_n = 1;
        endcase
    end

    assign wt_load   = (state_n != state);
    assign wt_val    = rst ? TW'(INIT_CYC - 1) : TW'(dur_n - 1);
    assign ref_ack   = (state_n == ST_RCAS) && (state != ST_RCAS);
    assign req_ready = accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_INIT;
            acc_q     <= '0;
            init_left <= IW'(INIT_REFS);
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            state <= state_n;
            if (accept) begin
                acc_q.row <= req_addr[ADDR_W-1:COL_W];
                acc_q.col <= req_addr[COL_W-1:0];
                acc_q.wr  <= req_write;
                acc_q.wd  <= req_wdata;
            end
            if (state == ST_RPRE && wt_done && init_left != '0)
                init_left <= init_left - 1'b1;
            rd_valid <= (state == ST_CAS) && wt_done && !acc_q.wr;
            if ((state == ST_CAS) && wt_done && !acc_q.wr)
                rd_data <= dram_dq_in;
        end
    end

    always_comb begin
        pins        = pins_of(state, acc_q.wr);
        dram_ras_n  = pins.ras_n;
        dram_cas_n  = pins.cas_n;
        dram_we_n   = pins.we_n;
        dram_oe_n   = pins.oe_n;
        dram_dq_oe  = pins.dq_oe;
        dram_dq_out = acc_q.wd;
        if (pins.row_sel)      dram_addr = acc_q.row;
        else if (pins.col_sel) dram_addr = ROW_W'(acc_q.col);
        else                   dram_addr = '0;
    end

endmodule

// File: rtl/dramc_ctrl_chk.sv
module dramc_ctrl_chk #(
    parameter int unsigned RP_CYC     = 2,
    parameter int unsigned RASMAX_CYC = 5000,
    parameter int unsigned INIT_CYC   = 10000
) (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic req_ready,
    input logic rd_valid
);
    localparam int unsigned LW = $clog2(RASMAX_CYC + 3);
    localparam int unsigned HW = $clog2(RP_CYC + 3);
    localparam int unsigned SW = $clog2(INIT_CYC + 3);

    logic [LW-1:0] lo_cnt;
    logic [HW-1:0] hi_cnt;
    logic [SW-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt    <= '0;
            hi_cnt    <= '0;
            since_rst <= '0;
        end else begin
            if (ras_n)                               lo_cnt <= '0;
            else if (lo_cnt != LW'(RASMAX_CYC + 2))  lo_cnt <= lo_cnt + 1'b1;
            if (!ras_n)                              hi_cnt <= '0;
            else if (hi_cnt != HW'(RP_CYC + 2))      hi_cnt <= hi_cnt + 1'b1;
            if (since_rst != SW'(INIT_CYC + 2))      since_rst <= since_rst + 1'b1;
        end
    end

    AST_RAS_LOW_MAX: assert property (@(posedge clk) disable iff (rst)
        32'(lo_cnt) <= RASMAX_CYC); // R6
    AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> 32'(hi_cnt) >= RP_CYC); // R5
    AST_CBR_WE_HIGH: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !cas_n) |-> we_n); // R7
    AST_CBR_CAS_FIRST: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n)); // R7
    AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && !we_n) |-> ($past(!we_n) && dq_oe && oe_n)); // R3
    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R2
    AST_READY_AFTER_INIT: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> 32'(since_rst) >= INIT_CYC); // R9
endmodule

bind dramc_ctrl dramc_ctrl_chk #(
    .RP_CYC(RP_CYC), .RASMAX_CYC(RASMAX_CYC), .INIT_CYC(INIT_CYC)
) u_chk (
    .clk(clk), .rst(rst), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
    .oe_n(dram_oe_n), .dq_oe(dram_dq_oe), .req_ready(req_ready), .rd_valid(rd_valid)
);

// File: tb/dramc_ctrl_test.sv
module dramc_ctrl_test;
    localparam int EXP_REFI   = 781;
    localparam int EXP_INIT   = 10000;
    localparam int EXP_RP     = 2;
    localparam int EXP_RASMAX = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [3:0]  rd_data;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [11:0] dram_addr;
    logic [3:0]  dram_dq_out;
    logic [3:0]  dram_dq_in = '0;

    int vectors = 0, fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dramc_ctrl #(.T_REFI_NS(15610), .T_RASMAX_NS(400)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    logic [3:0] shadow [int];
    logic [3:0] dmem [int];
    logic [3:0] sbq [$];

    int act_cnt = 0, cbr_cnt = 0, cbr_last = 0;
    int ras_hi_run = 0, ras_lo_run = 0, ras_lo_max = 0, reads_seen = 0;
    bit sat_on = 0;
    int sat_gaps = 0, sat_gap_max = 0;
    logic [11:0] cur_row = '0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;

    // Memory model and pin monitor, sampled between edges.
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_ras && !dram_ras_n) begin
                if (dram_cas_n) begin
                    act_cnt++;
                    cur_row = dram_addr;
                    chk(ras_hi_run >= EXP_RP, "R5 precharge cycles", ras_hi_run, EXP_RP);
                end else begin
                    chk(dram_we_n == 1'b1, "R7 we_n at refresh", dram_we_n, 1);
                    chk(prev_cas == 1'b0, "R7 cas low before ras", prev_cas, 0);
                    if (sat_on && cbr_cnt > 0) begin
                        sat_gaps++;
                        if (cyc - cbr_last > sat_gap_max) sat_gap_max = cyc - cbr_last;
                    end
                    cbr_cnt++;
                    cbr_last = cyc;
                end
            end
            if (prev_cas && !dram_cas_n && !dram_ras_n) begin
                chk(dram_addr[11:10] == 2'b00, "R1 upper pins in column phase", dram_addr[11:10], 0);
                if (!dram_we_n) begin
                    chk(prev_we == 1'b0, "R3 we_n low before cas", prev_we, 0);
                    chk(dram_dq_oe && dram_oe_n, "R3 bus driven, oe_n high",
                        {dram_dq_oe, dram_oe_n}, 3);
                    dmem[int'({cur_row, dram_addr[9:0]})] = dram_dq_out;
                end else begin
                    chk(dram_oe_n == 1'b0, "R2 oe_n low on read", dram_oe_n, 0);
                    dram_dq_in = dmem.exists(int'({cur_row, dram_addr[9:0]})) ?
                                 dmem[int'({cur_row, dram_addr[9:0]})] : 4'h0;
                end
            end
            if (dram_ras_n) begin
                ras_hi_run++;
                ras_lo_run = 0;
            end else begin
                ras_hi_run = 0;
                ras_lo_run++;
                if (ras_lo_run > ras_lo_max) ras_lo_max = ras_lo_run;
            end
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
            prev_we  = dram_we_n;
        end
    end

    // Scoreboard monitor for returned reads.
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            reads_seen++;
            if (sbq.size() == 0) begin
                chk(0, "R2 unexpected read pulse", rd_data, -1);
            end else begin
                logic [3:0] e;
                e = sbq.pop_front();
                chk(rd_data == e, "R2/R1 read data", rd_data, e);
            end
        end
    end

    task automatic issue(input bit wr, input logic [21:0] a, input logic [3:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        if (wr) shadow[int'(a)] = d;
        else    sbq.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_refresh();
        int c0;
        c0 = cbr_cnt;
        while (cbr_cnt == c0) @(negedge clk);
    endtask

    task automatic drain();
        repeat (40) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (R9 progress) actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R10 strobes idle",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        chk({dram_dq_oe, req_ready, rd_valid} == 3'b000, "R10 outputs low",
            {dram_dq_oe, req_ready, rd_valid}, 0);
        rst = 1'b0;

        // R9: held off during the power-up pause
        req_valid = 1'b1;
        req_write = 1'b0;
        while (cyc < 5000) @(negedge clk);
        #1;
        chk(req_ready == 1'b0, "R9 ready low mid-pause", req_ready, 0);
        req_valid = 1'b0;
        #1;
        req_valid = 1'b1;
        req_addr  = 22'h0;
        shadow[0] = 4'h0;
        begin
            int t_ready;
            #1;
            while (!req_ready) begin
                @(negedge clk);
                #1;
            end
            t_ready = cyc;
            chk(t_ready >= EXP_INIT, "R9/R11 pause length", t_ready, EXP_INIT);
            chk(cbr_cnt >= 8, "R9 init refresh count", cbr_cnt, 8);
            sbq.push_back(4'h0);
            @(negedge clk);
            req_valid = 1'b0;
        end
        drain();

        // R1, R2, R3, R5: single accesses across different rows
        issue(1, {12'h5A3, 10'h3C1}, 4'h9);
        issue(1, {12'hFFF, 10'h3FF}, 4'hF);
        issue(1, {12'h001, 10'h000}, 4'h1);
        issue(0, {12'h5A3, 10'h3C1}, 4'h0);
        issue(0, {12'hFFF, 10'h3FF}, 4'h0);
        issue(0, {12'h001, 10'h000}, 4'h0);
        drain();

        // R4: same-row burst right after a refresh uses one activation
        wait_refresh();
        drain();
        begin
            int a0;
            a0 = act_cnt;
            for (int i = 0; i < 4; i++)
                issue(1, {12'h2B7, 10'(i * 5)}, 4'(i + 6));
            drain();
            chk(act_cnt - a0 == 1, "R4 activations in page burst", act_cnt - a0, 1);
        end

        // R6: long same-row burst is split by the RAS-low limit
        begin
            int a0;
            a0 = act_cnt;
            for (int i = 0; i < 10; i++)
                issue(0, {12'h2B7, 10'((i % 4) * 5)}, 4'h0);
            drain();
            chk(act_cnt - a0 >= 2, "R6 long burst split", act_cnt - a0, 2);
        end

        // R7, R11: idle refresh spacing
        begin
            int t0;
            wait_refresh();
            t0 = cbr_last;
            wait_refresh();
            chk(cbr_last - t0 == EXP_REFI, "R7/R11 idle refresh interval", cbr_last - t0, EXP_REFI);
        end

        // R8: refresh keeps its spacing under saturating traffic
        sat_on = 1;
        for (int i = 0; i < 220; i++) begin
            logic [21:0] a;
            a = {12'((i * 37) % 4096), 10'((i * 11) % 1024)};
            issue(1, a, 4'(i) ^ a[13:10]);
            issue(0, a, 4'h0);
        end
        sat_on = 0;
        drain();
        chk(sat_gaps >= 1, "R8 refreshes under traffic", sat_gaps, 1);
        chk(sat_gap_max <= EXP_REFI + 30, "R8 refresh spacing bound", sat_gap_max, EXP_REFI + 30);

        chk(ras_lo_max <= EXP_RASMAX, "R6 longest RAS-low run", ras_lo_max, EXP_RASMAX);
        chk(sbq.size() == 0, "R2 all reads returned", sbq.size(), 0);
        finish_run();
    end
endmodule